// File: doc/BRIEF.md
# Car Park Occupancy Counter

This block keeps a running tally of the vehicles inside a car park that holds at most `CAPACITY` cars. An entry sensor and an exit sensor each deliver a one-cycle pulse per vehicle. The block raises or lowers its tally by one in response, so a display driver and the park's admission logic always see the current occupancy.

The tally stays between zero and `CAPACITY`. A pulse that would push it past either limit is dropped. An entry and an exit seen on the same clock edge cancel each other, because the occupancy is then unchanged. Each accepted movement updates the registered count output. In the same cycle as that update, a one-cycle strobe tells the display to refresh. Two level flags, full and empty, come from the registered tally.

Top module: `occupancy_counter`

## Requirements
- R1: After reset the count is zero, the change strobe is low, the empty flag is high and the full flag is low.
- R2: An entry pulse with no exit pulse, taken at an edge where the count is below CAPACITY, makes the count one larger from that edge on, and the change strobe is high in that same cycle.
- R3: An exit pulse with no entry pulse, taken at an edge where the count is above zero, makes the count one smaller from that edge on, and the change strobe is high in that same cycle.
- R4: Entry and exit pulses at the same edge leave the count unchanged and keep the change strobe low.
- R5: An entry pulse alone at a count of CAPACITY is ignored: the count stays at CAPACITY and the change strobe stays low.
- R6: An exit pulse alone at a count of zero is ignored: the count stays at zero and the change strobe stays low.
- R7: The full flag is high exactly when the count equals CAPACITY. The empty flag is high exactly when the count equals zero.
- R8: The change strobe is high for a cycle only if the count in that cycle differs from the count in the cycle before. It is low after an edge with no pulse.
- R9: The count never exceeds CAPACITY. Its width is ceil(log2(CAPACITY+1)) bits, and CAPACITY defaults to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_in | input | 1 | One-cycle pulse per vehicle entering |
| car_out | input | 1 | One-cycle pulse per vehicle leaving |
| occupancy | output | ceil(log2(CAPACITY+1)) | Registered vehicle count |
| occ_changed | output | 1 | High for the cycle in which occupancy has just changed |
| lot_full | output | 1 | Count equals CAPACITY |
| lot_empty | output | 1 | Count equals zero |

## Verification
The assertions assume that `car_in` and `car_out` are clean synchronous levels, sampled once per rising edge, with one cycle of level meaning one vehicle. They also assume CAPACITY is at least one, so full and empty are never high together. The stimulus drives both inputs only on falling edges and holds them for a single period. It walks the tally past both limits and applies coincident pulses at zero, mid-range and CAPACITY, so every guard sees both legal and refused movements.

// File: rtl/occ_pkg.sv
package occ_pkg;

    // Net movement requested at one clock edge
    typedef enum logic [1:0] {
        MOVE_NONE = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_e;

endpackage

// File: rtl/occ_move_decode.sv
module occ_move_decode
    import occ_pkg::*;
(
    input  logic  arrive,
    input  logic  depart,
    output move_e move
);

    // Coincident arrival and departure cancel to no movement
    always_comb begin
        unique case ({arrive, depart})
            2'b10:   move = MOVE_UP;
            2'b01:   move = MOVE_DOWN;
            default: move = MOVE_NONE;
        endcase
    end

endmodule

// File: rtl/occ_limit_guard.sv
module occ_limit_guard
    import occ_pkg::*;
#(
    parameter int CAPACITY = 15,
    parameter int CW       = $clog2(CAPACITY + 1)
) (
    input  move_e         move,
    input  logic [CW-1:0] tally,
    output logic          go_up,
    output logic          go_down,
    output logic          at_top,
    output logic          at_bottom
);

    localparam logic [CW-1:0] TOP = CW'(CAPACITY);

    always_comb begin
        at_top    = (tally == TOP);
        at_bottom = (tally == '0);
        go_up     = (move == MOVE_UP)   && !at_top;
        go_down   = (move == MOVE_DOWN) && !at_bottom;
    end

endmodule

// File: rtl/occupancy_counter.sv
module occupancy_counter
    import occ_pkg::*;
#(
    parameter  int CAPACITY = 15,
    localparam int CW       = $clog2(CAPACITY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          car_in,
    input  logic          car_out,
    output logic [CW-1:0] occupancy,
    output logic          occ_changed,
    output logic          lot_full,
    output logic          lot_empty
);

    localparam logic [CW-1:0] TOP = CW'(CAPACITY);

    typedef struct packed {
        logic [CW-1:0] tally;
        logic          strobe;
    } occ_state_t;

    occ_state_t st_d, st_q;
    move_e      move_w;
    logic       up_w, down_w, top_w, bottom_w;

    occ_move_decode u_decode (
        .arrive (car_in),
        .depart (car_out),
        .move   (move_w)
    );

    occ_limit_guard #(
        .CAPACITY (CAPACITY),
        .CW       (CW)
    ) u_guard (
        .move      (move_w),
        .tally     (st_q.tally),
        .go_up     (up_w),
        .go_down   (down_w),
        .at_top    (top_w),
        .at_bottom (bottom_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (up_w) begin
            st_d.tally  = st_q.tally + 1'b1;
            st_d.strobe = 1'b1;
        end else if (down_w) begin
            st_d.tally  = st_q.tally - 1'b1;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occupancy   = st_q.tally;
    assign occ_changed = st_q.strobe;
    assign lot_full    = top_w;
    assign lot_empty   = bottom_w;

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (car_in && !car_out && occupancy < TOP)
        |=> (occupancy == $past(occupancy) + 1'b1) && occ_changed);

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (car_out && !car_in && occupancy != '0)
        |=> (occupancy == $past(occupancy) - 1'b1) && occ_changed);

    a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (car_in && car_out) |=> $stable(occupancy) && !occ_changed);

    a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (car_in && !car_out && occupancy == TOP)
        |=> (occupancy == TOP) && !occ_changed);

    a_r6_hold_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (car_out && !car_in && occupancy == '0)
        |=> (occupancy == '0) && !occ_changed);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lot_full, lot_empty}));

    a_r8_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!car_in && !car_out) |=> !occ_changed && $stable(occupancy));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= TOP);

endmodule

// File: tb/tb_occupancy_counter.sv
module tb_occupancy_counter;

    localparam int CAP = 15;
    localparam int CW  = $clog2(CAP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          car_in = 1'b0;
    logic          car_out = 1'b0;
    logic [CW-1:0] occupancy;
    logic          occ_changed, lot_full, lot_empty;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 1'b0;

    typedef struct {
        int    cnt;
        bit    chg;
        string tag;
    } exp_t;

    exp_t sb[$];

    occupancy_counter #(.CAPACITY(CAP)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .car_in      (car_in),
        .car_out     (car_out),
        .occupancy   (occupancy),
        .occ_changed (occ_changed),
        .lot_full    (lot_full),
        .lot_empty   (lot_empty)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of pulses and queues the expected result
    task automatic drive(input bit en, input bit lv);
        exp_t e;
        @(negedge clk);
        car_in  = en;
        car_out = lv;
        if (en && lv)            begin e.tag = "R4"; e.chg = 0; end
        else if (en && model < CAP) begin e.tag = "R2"; e.chg = 1; model++; end
        else if (en)             begin e.tag = "R5"; e.chg = 0; end
        else if (lv && model > 0) begin e.tag = "R3"; e.chg = 1; model--; end
        else if (lv)             begin e.tag = "R6"; e.chg = 0; end
        else                     begin e.tag = "R8"; e.chg = 0; end
        e.cnt = model;
        sb.push_back(e);
    endtask

    // Monitor: compares the outputs settled after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(int'(occupancy) == e.cnt, {e.tag, " count"}, int'(occupancy), e.cnt);
                check(occ_changed == e.chg, {e.tag, " strobe"}, int'(occ_changed), int'(e.chg));
                check(lot_full == (e.cnt == CAP), "R7 full", int'(lot_full), int'(e.cnt == CAP));
                check(lot_empty == (e.cnt == 0), "R7 empty", int'(lot_empty), int'(e.cnt == 0));
                check(int'(occupancy) <= CAP, "R9 bound", int'(occupancy), CAP);
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(occupancy == '0, "R1 count", int'(occupancy), 0);
        check(occ_changed == 1'b0, "R1 strobe", int'(occ_changed), 0);
        check(lot_empty == 1'b1, "R1 empty", int'(lot_empty), 1);
        check(lot_full == 1'b0, "R1 full", int'(lot_full), 0);
        rst_n = 1'b1;

        drive(0, 1);                               // R6 at empty
        drive(1, 1);                               // R4 at empty
        for (int i = 0; i < 7; i++) drive(1, 0);   // R2 climb
        drive(1, 1);                               // R4 mid-range
        drive(0, 0);                               // R8 idle
        for (int i = 0; i < 12; i++) drive(1, 0);  // reach CAP, then R5
        drive(1, 1);                               // R4 at full
        drive(0, 0);
        for (int i = 0; i < 6; i++) drive(0, 1);   // R3 descent
        for (int i = 0; i < 8; i++) begin          // alternating pattern
            drive(1, 0);
            drive(0, 1);
            drive(0, 0);
        end
        for (int i = 0; i < 14; i++) drive(0, 1);  // reach zero, then R6
        drive(1, 0);
        drive(0, 0);

        @(negedge clk);
        car_in  = 1'b0;
        car_out = 1'b0;
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule